// File: doc/BRIEF.md
# Serial EEPROM Write Protection Controller

This block decides whether a write to a serial EEPROM may go ahead. It holds the write-enable latch and the nonvolatile protection fields of the status register. It watches the decoded command strobes, the chip-select line, the active-low write-protect pin and the busy flag of the write engine. When chip select rises at the end of a write sequence, the block issues a one-cycle grant for a status write or for an array write. It refuses the write if any protection rule forbids it.

Protection works in three ways. First, the write-enable latch must have been set by an enable command, and it is cleared again by a disable command, by a refused write sequence, or when the write engine finishes a cycle. Second, a pin-lock bit in the status register arms the write-protect pin. While that bit is set, a low pin at any point of a status write sequence blocks the write, and a pin change after the write has been granted has no effect. Third, a two-bit block-protect code shields none of the array, its upper quarter, its upper half or all of it from array writes.

Serial shifting, command decoding and the memory array are outside this block. All inputs are synchronous to `clk`.

Top module: `eeprom_wprot_ctrl`

## Requirements
- R1: After reset, the status output reads pin-lock = DEF_LOCK (bit 7), block-protect = DEF_BP (bits 3:2), latch = 0 (bit 1) and busy (bit 0). Both grants are 0.
- R2: A pulse on `op_setwe_i` sets the write-enable latch (status bit 1) on the next clock. A pulse on `op_clrwe_i` clears it.
- R3: Status bit 0 follows `busy_i` with no delay. Bits 6:4 always read 0.
- R4: A status write sequence is granted when the latch is 1, `busy_i` is 0 and no pin lock applies. The grant loads bit 7 of `sr_wdata_i` into the pin-lock bit and bits 3:2 into the block-protect code. All other data bits are ignored.
- R5: With the pin-lock bit at 1, a status write is refused if `wp_n_i` is low when chip select rises. The status fields stay unchanged.
- R6: With the pin-lock bit at 1, a low `wp_n_i` in any cycle while chip select is low during an open status write sequence cancels that write, even if the pin is high again when chip select rises.
- R7: With the pin-lock bit at 0, `wp_n_i` has no effect on status writes.
- R8: After a status write has been granted, a later falling edge on `wp_n_i` leaves the written fields unchanged.
- R9: Block-protect code 00 protects nothing. Code 01 protects addresses at or above 3/4 of the array depth. Code 10 protects addresses at or above half the depth. Code 11 protects every address. An array write to a protected address is refused.
- R10: An array write is granted only when the latch is 1, `busy_i` is 0 and the address is unprotected.
- R11: The latch clears on the clock after `busy_i` falls. It also clears when a write sequence that was opened is refused.
- R12: Grants are one-cycle pulses. They are never both high, and they appear in the cycle after the clock edge that first sees chip select high.
- R13: A chip-select rise with no write sequence open produces no grant and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Chip select, active low |
| wp_n_i | input | 1 | Write-protect pin, active low |
| busy_i | input | 1 | Write engine busy |
| op_setwe_i | input | 1 | Write-enable command strobe |
| op_clrwe_i | input | 1 | Write-disable command strobe |
| op_stwr_i | input | 1 | Opens a status write sequence |
| op_arwr_i | input | 1 | Opens an array write sequence |
| sr_wdata_i | input | 8 | Status write data, valid at chip-select rise |
| wr_addr_i | input | ADDR_W | Array write address, valid at chip-select rise |
| status_o | output | 8 | Status register value |
| sr_grant_o | output | 1 | Status write granted (one cycle) |
| arr_grant_o | output | 1 | Array write granted (one cycle) |

## Verification
The grant decision is tried with pin waveforms that stay high, stay low, or dip low only mid-sequence, each with the pin lock set and cleared. This separates a check made only at chip-select rise from one held across the whole sequence, and shows that a cleared lock makes the pin irrelevant. Array writes hit addresses just below and just at the quarter and half boundaries under every protect code, which exposes off-by-one boundaries and swapped codes. Seeded random sequences mix latch commands, busy windows and both write kinds to catch latch-clearing errors that directed cases miss.

// File: rtl/eeprom_wprot_pkg.sv
package eeprom_wprot_pkg;

   typedef enum logic [1:0] {
      SEQ_NONE   = 2'd0,
      SEQ_STATUS = 2'd1,
      SEQ_ARRAY  = 2'd2
   } seq_kind_t;

   localparam int SR_W       = 8;
   localparam int SR_BUSY    = 0;
   localparam int SR_LATCH   = 1;
   localparam int SR_BP_LO   = 2;
   localparam int SR_BP_HI   = 3;
   localparam int SR_LOCK    = 7;
   localparam int BP_CODES   = 4;

endpackage

// File: rtl/wprot_seq_track.sv
module wprot_seq_track
   import eeprom_wprot_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cs_n_i,
   input  logic      wp_n_i,
   input  logic      lock_en_i,
   input  logic      op_st_i,
   input  logic      op_ar_i,
   output logic      cs_rise_o,
   output seq_kind_t kind_o,
   output logic      cancel_o
);

   logic      cs_q;
   logic      cs_fall;
   seq_kind_t kind_q;
   logic      cancel_q;

   assign cs_rise_o = cs_n_i & ~cs_q;
   assign cs_fall   = ~cs_n_i & cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= 1'b1;
      end else begin
         cs_q <= cs_n_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= SEQ_NONE;
         cancel_q <= 1'b0;
      end else if (cs_rise_o || cs_fall) begin
         kind_q   <= SEQ_NONE;
         cancel_q <= 1'b0;
      end else if (op_st_i) begin
         kind_q   <= SEQ_STATUS;
         cancel_q <= 1'b0;
      end else if (op_ar_i) begin
         kind_q   <= SEQ_ARRAY;
         cancel_q <= 1'b0;
      end else if (kind_q == SEQ_STATUS && !cs_n_i && lock_en_i && !wp_n_i) begin
         cancel_q <= 1'b1;
      end
   end

   assign kind_o   = kind_q;
   assign cancel_o = cancel_q;

   // R13: a closed sequence leaves nothing open behind it
   a_r13_seq_closed: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise_o |=> (kind_q == SEQ_NONE));

   // R6: a cancel mark only ever belongs to a status sequence
   a_r6_cancel_kind: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_q |-> (kind_q == SEQ_STATUS));

endmodule

// File: rtl/wprot_range_chk.sv
module wprot_range_chk
   import eeprom_wprot_pkg::*;
#(
   parameter int ADDR_W = 15
)(
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [1:0]        bp_i,
   output logic              prot_o
);

   localparam int CMP_W = ADDR_W + 1;

   logic [BP_CODES-1:0] hit;

   generate
      if (ADDR_W < 2 || ADDR_W > 31) begin : g_bad_width
         $error("wprot_range_chk: ADDR_W out of range");
      end
      for (genvar g = 0; g < BP_CODES; g++) begin : g_code
         if (g == 0) begin : g_none
            assign hit[g] = 1'b0;
         end else if (g == BP_CODES - 1) begin : g_all
            assign hit[g] = 1'b1;
         end else begin : g_upper
            localparam logic [CMP_W-1:0] LIMIT =
               CMP_W'(BP_CODES - g) << (ADDR_W - 2);
            assign hit[g] = ({1'b0, addr_i} >= LIMIT);
         end
      end
   endgenerate

   assign prot_o = hit[bp_i];

endmodule

// File: rtl/wprot_wel.sv
module wprot_wel (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   input  logic refuse_i,
   input  logic busy_i,
   output logic wel_o
);

   logic busy_q;
   logic done;
   logic wel_q;

   assign done = busy_q & ~busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wel_q  <= 1'b0;
      end else begin
         busy_q <= busy_i;
         if (clr_i || refuse_i || done) begin
            wel_q <= 1'b0;
         end else if (set_i) begin
            wel_q <= 1'b1;
         end
      end
   end

   assign wel_o = wel_q;

   // R11: the end of a write cycle drops the latch
   a_r11_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !busy_i) |=> !wel_q);

   // R2: a disable command always leaves the latch low
   a_r2_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !wel_q);

   // R11: a refused sequence leaves the latch low
   a_r11_refuse_clears: assert property (@(posedge clk) disable iff (!rst_n)
      refuse_i |=> !wel_q);

endmodule

// File: rtl/wprot_status_fields.sv
module wprot_status_fields #(
   parameter logic [1:0] DEF_BP   = 2'b00,
   parameter logic       DEF_LOCK = 1'b0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we_i,
   input  logic [1:0] bp_new_i,
   input  logic       lock_new_i,
   output logic [1:0] bp_o,
   output logic       lock_o
);

   logic [1:0] bp_q;
   logic       lock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bp_q   <= DEF_BP;
         lock_q <= DEF_LOCK;
      end else if (we_i) begin
         bp_q   <= bp_new_i;
         lock_q <= lock_new_i;
      end
   end

   assign bp_o   = bp_q;
   assign lock_o = lock_q;

   // R5 R8: fields move only on a granted status write
   a_r8_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable({lock_q, bp_q}));

endmodule

// File: rtl/eeprom_wprot_ctrl.sv
module eeprom_wprot_ctrl
   import eeprom_wprot_pkg::*;
#(
   parameter int         ADDR_W   = 15,
   parameter logic [1:0] DEF_BP   = 2'b00,
   parameter logic       DEF_LOCK = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              wp_n_i,
   input  logic              busy_i,
   input  logic              op_setwe_i,
   input  logic              op_clrwe_i,
   input  logic              op_stwr_i,
   input  logic              op_arwr_i,
   input  logic [7:0]        sr_wdata_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   output logic [7:0]        status_o,
   output logic              sr_grant_o,
   output logic              arr_grant_o
);

   generate
      if (SR_W != 8) begin : g_bad_sr
         $error("eeprom_wprot_ctrl: status width must be 8");
      end
   endgenerate

   logic      cs_rise;
   seq_kind_t kind;
   logic      cancel;
   logic      wel;
   logic [1:0] bp;
   logic      lock_en;
   logic      prot;
   logic      pin_lock;
   logic      st_try, ar_try;
   logic      st_ok, ar_ok;
   logic      refuse;
   logic      st_grant_q, ar_grant_q;
   logic      data_unused;

   wprot_seq_track u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n_i    (cs_n_i),
      .wp_n_i    (wp_n_i),
      .lock_en_i (lock_en),
      .op_st_i   (op_stwr_i),
      .op_ar_i   (op_arwr_i),
      .cs_rise_o (cs_rise),
      .kind_o    (kind),
      .cancel_o  (cancel)
   );

   wprot_range_chk #(.ADDR_W(ADDR_W)) u_range (
      .addr_i (wr_addr_i),
      .bp_i   (bp),
      .prot_o (prot)
   );

   assign pin_lock = lock_en & ~wp_n_i;
   assign st_try   = cs_rise & (kind == SEQ_STATUS);
   assign ar_try   = cs_rise & (kind == SEQ_ARRAY);
   assign st_ok    = st_try & wel & ~busy_i & ~cancel & ~pin_lock;
   assign ar_ok    = ar_try & wel & ~busy_i & ~prot;
   assign refuse   = (st_try & ~st_ok) | (ar_try & ~ar_ok);

   wprot_wel u_wel (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (op_setwe_i),
      .clr_i    (op_clrwe_i),
      .refuse_i (refuse),
      .busy_i   (busy_i),
      .wel_o    (wel)
   );

   wprot_status_fields #(.DEF_BP(DEF_BP), .DEF_LOCK(DEF_LOCK)) u_fields (
      .clk        (clk),
      .rst_n      (rst_n),
      .we_i       (st_ok),
      .bp_new_i   (sr_wdata_i[SR_BP_HI:SR_BP_LO]),
      .lock_new_i (sr_wdata_i[SR_LOCK]),
      .bp_o       (bp),
      .lock_o     (lock_en)
   );

   assign data_unused = ^{sr_wdata_i[6:4], sr_wdata_i[1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_grant_q <= 1'b0;
         ar_grant_q <= 1'b0;
      end else begin
         st_grant_q <= st_ok;
         ar_grant_q <= ar_ok;
      end
   end

   always_comb begin
      status_o           = '0;
      status_o[SR_BUSY]  = busy_i;
      status_o[SR_LATCH] = wel;
      status_o[SR_BP_HI:SR_BP_LO] = bp;
      status_o[SR_LOCK]  = lock_en;
   end

   assign sr_grant_o  = st_grant_q;
   assign arr_grant_o = ar_grant_q;

   // R12: never both grants at once
   a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_grant_q && ar_grant_q));

   // R12: a grant lasts one cycle
   a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (st_grant_q || ar_grant_q) |=> !(st_grant_q || ar_grant_q));

   // R4: a status grant needs the latch and an idle engine
   a_r4_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      st_grant_q |-> $past(wel && !busy_i));

   // R5 R7: no status grant while the armed pin is low
   a_r5_pin_block: assert property (@(posedge clk) disable iff (!rst_n)
      st_grant_q |-> $past(!(lock_en && !wp_n_i)));

   // R10: an array grant needs the latch and an idle engine
   a_r10_arr_latch: assert property (@(posedge clk) disable iff (!rst_n)
      ar_grant_q |-> $past(wel && !busy_i));

   // R9: no array grant to a protected address
   a_r9_no_prot_write: assert property (@(posedge clk) disable iff (!rst_n)
      ar_grant_q |-> $past(!prot));

   // R3: unused status bits stay zero
   a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6:4] == 3'b000);

endmodule

// File: tb/eeprom_wprot_ctrl_tb_top.sv
module eeprom_wprot_ctrl_tb_top;

   localparam int CLK_P = 10;
   localparam int AW    = 15;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1;
   logic          wp_n = 1'b1;
   logic          busy = 1'b0;
   logic          op_set = 1'b0, op_clr = 1'b0, op_st = 1'b0, op_ar = 1'b0;
   logic [7:0]    wdata = '0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    status;
   logic          sr_grant, arr_grant;

   int n_cmp = 0;
   int n_bad = 0;

   logic       m_wel  = 1'b0;
   logic [1:0] m_bp   = 2'b00;
   logic       m_lock = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   eeprom_wprot_ctrl #(.ADDR_W(AW), .DEF_BP(2'b00), .DEF_LOCK(1'b0)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_n_i      (cs_n),
      .wp_n_i      (wp_n),
      .busy_i      (busy),
      .op_setwe_i  (op_set),
      .op_clrwe_i  (op_clr),
      .op_stwr_i   (op_st),
      .op_arwr_i   (op_ar),
      .sr_wdata_i  (wdata),
      .wr_addr_i   (addr),
      .status_o    (status),
      .sr_grant_o  (sr_grant),
      .arr_grant_o (arr_grant)
   );

   function automatic logic is_prot(input logic [1:0] code, input int a);
      case (code)
         2'b00:   return 1'b0;
         2'b01:   return a >= (DEPTH / 4) * 3;
         2'b10:   return a >= DEPTH / 2;
         default: return 1'b1;
      endcase
   endfunction

   function automatic logic [7:0] exp_sr(input logic b);
      return {m_lock, 3'b000, m_bp, m_wel, b};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_we();
      op_set = 1'b1; tick(1); op_set = 1'b0; tick(1);
      m_wel = 1'b1;
      chk("R2 latch set", status[1], 1'b1);
   endtask

   task automatic clr_we();
      op_clr = 1'b1; tick(1); op_clr = 1'b0; tick(1);
      m_wel = 1'b0;
      chk("R2 latch clear", status[1], 1'b0);
   endtask

   task automatic busy_cycle(input int n);
      busy = 1'b1; tick(1);
      chk("R3 busy bit", status, exp_sr(1'b1));
      tick(n);
      busy = 1'b0; tick(1);
      m_wel = 1'b0;
      chk("R11 latch after busy", status, exp_sr(1'b0));
   endtask

   // one write sequence; is_st selects status or array
   task automatic do_seq(input logic is_st, input logic [7:0] d, input int a,
                         input logic wp_mid, input logic wp_end, input logic bsy,
                         input string tag);
      logic ok;
      if (is_st)
         ok = m_wel & ~bsy & ~(m_lock & (~wp_mid | ~wp_end));
      else
         ok = m_wel & ~bsy & ~is_prot(m_bp, a);
      busy = bsy;
      cs_n = 1'b0; tick(1);
      if (is_st) op_st = 1'b1; else op_ar = 1'b1;
      wdata = d; addr = AW'(a);
      tick(1);
      op_st = 1'b0; op_ar = 1'b0; wp_n = wp_mid;
      tick(1);
      wp_n = wp_end;
      tick(1);
      cs_n = 1'b1;
      tick(1);
      if (is_st && ok) begin
         m_lock = d[7];
         m_bp   = d[3:2];
      end
      if (!ok) m_wel = 1'b0;
      chk({tag, " status grant"}, sr_grant, is_st & ok);
      chk({tag, " array grant"}, arr_grant, ~is_st & ok);
      chk({tag, " status value"}, status, exp_sr(bsy));
      wp_n = 1'b1;
      tick(1);
      chk("R12 grant pulse ends", {sr_grant, arr_grant}, 2'b00);
      if (bsy) begin
         busy = 1'b0; tick(1);
         m_wel = 1'b0;
         chk("R11 latch after busy", status, exp_sr(1'b0));
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int rv;
      rv = $urandom(32'h1A2B3C);
      tick(3);
      // R1 R3: reset state
      chk("R1 reset status", status, 8'h00);
      chk("R1 reset grants", {sr_grant, arr_grant}, 2'b00);
      rst_n = 1'b1;
      tick(2);
      chk("R1 status after reset", status, exp_sr(1'b0));

      // R10: array write without latch is refused
      do_seq(1'b0, 8'h00, 5, 1'b1, 1'b1, 1'b0, "R10 no latch");
      // R2
      set_we();
      clr_we();
      // R13: empty chip-select pulse
      set_we();
      cs_n = 1'b0; tick(2); cs_n = 1'b1; tick(1);
      chk("R13 no grant", {sr_grant, arr_grant}, 2'b00);
      chk("R13 latch kept", status[1], 1'b1);
      // R4: status write with ignored bits set
      do_seq(1'b1, 8'b1111_0111, 0, 1'b1, 1'b1, 1'b0, "R4 write");
      chk("R4 fields", status, 8'b1000_0110);
      busy_cycle(3);
      // R8: pin falls after grant
      wp_n = 1'b0; tick(4);
      chk("R8 fields unchanged", status, exp_sr(1'b0));
      wp_n = 1'b1; tick(1);
      // R5: pin low throughout
      set_we();
      do_seq(1'b1, 8'h00, 0, 1'b0, 1'b0, 1'b0, "R5 pin low");
      // R6: pin dip mid-sequence
      set_we();
      do_seq(1'b1, 8'h00, 0, 1'b0, 1'b1, 1'b0, "R6 pin dip");
      // R4 with busy engine
      set_we();
      do_seq(1'b1, 8'h00, 0, 1'b1, 1'b1, 1'b1, "R4 busy");
      // clear lock, then R7
      set_we();
      do_seq(1'b1, 8'h00, 0, 1'b1, 1'b1, 1'b0, "R7 unlock");
      set_we();
      do_seq(1'b1, 8'h08, 0, 1'b0, 1'b0, 1'b0, "R7 pin ignored");
      chk("R7 bp loaded", status[3:2], 2'b10);

      // R9: every code against boundary addresses
      for (int c = 0; c < 4; c++) begin
         set_we();
         do_seq(1'b1, 8'(c << 2), 0, 1'b1, 1'b1, 1'b0, "R9 set code");
         for (int k = 0; k < 6; k++) begin
            int a;
            case (k)
               0: a = 0;
               1: a = DEPTH/2 - 1;
               2: a = DEPTH/2;
               3: a = (DEPTH/4)*3 - 1;
               4: a = (DEPTH/4)*3;
               default: a = DEPTH - 1;
            endcase
            set_we();
            do_seq(1'b0, 8'h00, a, 1'b1, 1'b1, 1'b0, "R9 range");
         end
      end

      // constrained random mix
      for (int it = 0; it < 250; it++) begin
         int sel;
         sel = $urandom_range(0, 9);
         case (sel)
            0: clr_we();
            1, 2: set_we();
            3: busy_cycle($urandom_range(1, 4));
            4, 5: do_seq(1'b1, 8'($urandom), 0, 1'($urandom), 1'($urandom),
                         ($urandom_range(0, 5) == 0), "R4 R6 random status");
            default: do_seq(1'b0, 8'h00, $urandom_range(0, DEPTH - 1),
                            1'($urandom), 1'($urandom),
                            ($urandom_range(0, 5) == 0), "R9 R10 random array");
         endcase
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule